// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out, in pure combinational logic, which address a 32-bit processor fetches next. Each cycle it is given the current program counter, the instruction word being executed, and the values already read from the two source registers (named rs and rt after their instruction fields). From these it produces the next program counter, a write enable for the link register (register 31), and the link value.

Straight-line code advances by one word. The block handles region-relative absolute jumps, jump-and-link, jump through a register, branches on register equality or inequality, and branches on the sign of rs. Branch and jump targets are based on the already-incremented PC. The link value follows the delay-slot convention, so it is PC+8. The surrounding PC register, instruction memory and any pipeline sit outside the block and use its outputs directly.

The interface is a set of plain control and address pins with no handshake. Every output is a function of the current inputs only. There is no state and no back-pressure.

Top module: `npc_unit`

## Requirements
- R1: For any opcode (instruction bits 31:26) other than 0x1 through 0x7, and for opcode 0x0 with a function field (bits 5:0) other than 0x08, next_pc is pc+4 modulo 2^32 and link_we is 0.
- R2: Opcode 0x2 sets next_pc to {bits 31:28 of pc+4, instruction bits 25:0, 2'b00} with link_we 0.
- R3: Opcode 0x3 sets next_pc the same way as R2 and raises link_we. link_val is pc+8 modulo 2^32 for every instruction, and link_we is 1 only for opcode 0x3.
- R4: Opcode 0x0 with function 0x08 sets next_pc to rs_val with link_we 0.
- R5: Opcode 0x4 is taken when rs_val equals rt_val, and opcode 0x5 when they differ. A taken branch gives pc+4 plus the 16-bit offset (bits 15:0), sign-extended and shifted left by two. A branch that is not taken gives pc+4.
- R6: Opcode 0x1 reads a sub-opcode from bits 20:16. Value 0 is taken when rs_val is negative, and value 1 is taken when rs_val is zero or positive. Any other value falls through to pc+4. Targets are as in R5.
- R7: Opcode 0x6 is taken when rs_val is less than or equal to zero, and opcode 0x7 when rs_val is strictly greater than zero. Bits 20:16 are ignored. All sign tests in R6 and R7 treat rs_val as signed two's complement.
- R8: The region of a jump comes from pc+4, not from pc. A jump at pc 0x2FFFFFFC lands in the 0x3xxxxxxx region, while a jump at 0x2FFFFFF8 stays in 0x2xxxxxxx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Value of the register named in bits 25:21 |
| rt_val | input | 32 | Value of the register named in bits 20:16 |
| next_pc | output | 32 | Address of the next instruction to fetch |
| link_we | output | 1 | Write enable for register 31 |
| link_val | output | 32 | Return address to write into register 31 |

## Verification
The block holds no state, so a fault shows up in the same cycle as the instruction that triggers it. A wrong decode or a wrong condition test shows as a next_pc that is off by a branch offset, stuck at pc+4, or carrying the wrong upper nibble. It can also show as link_we firing on a jump that does not link. The hard cases are offsets of zero and -1, rs values at zero, at -1 and at the most negative number, sub-opcodes other than 0 and 1, and jumps that cross a region boundary. The bench hits these cases both as directed vectors and inside a long pseudo-random stream.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned FN_W     = 6;
  localparam int unsigned REGF_W   = 5;
  localparam int unsigned OFS_W    = 16;
  localparam int unsigned JIDX_W   = 26;
  localparam int unsigned OPC_LSB  = 26;
  localparam int unsigned RT_LSB   = 16;

  localparam logic [OPC_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OP_REGIMM  = 6'h01;
  localparam logic [OPC_W-1:0] OP_JUMP    = 6'h02;
  localparam logic [OPC_W-1:0] OP_JLINK   = 6'h03;
  localparam logic [OPC_W-1:0] OP_BREQ    = 6'h04;
  localparam logic [OPC_W-1:0] OP_BRNE    = 6'h05;
  localparam logic [OPC_W-1:0] OP_BRLEZ   = 6'h06;
  localparam logic [OPC_W-1:0] OP_BRGTZ   = 6'h07;
  localparam logic [FN_W-1:0]  FN_JREG    = 6'h08;
  localparam logic [REGF_W-1:0] SUB_LTZ   = 5'd0;
  localparam logic [REGF_W-1:0] SUB_GEZ   = 5'd1;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_JABS,
    FLOW_JREG,
    FLOW_BRANCH
  } flow_e;

  typedef enum logic [2:0] {
    TEST_EQ,
    TEST_NE,
    TEST_LTZ,
    TEST_GEZ,
    TEST_LEZ,
    TEST_GTZ,
    TEST_NEVER
  } test_e;

  typedef struct packed {
    flow_e               flow;
    test_e               test;
    logic                link;
    logic [OFS_W-1:0]    ofs;
    logic [JIDX_W-1:0]   jidx;
  } dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);
  logic [OPC_W-1:0]  opc;
  logic [FN_W-1:0]   fn;
  logic [REGF_W-1:0] sub;

  assign opc = instr[OPC_LSB +: OPC_W];
  assign fn  = instr[FN_W-1:0];
  assign sub = instr[RT_LSB +: REGF_W];

  always_comb begin
    dec.flow = FLOW_SEQ;
    dec.test = TEST_NEVER;
    dec.link = 1'b0;
    dec.ofs  = instr[OFS_W-1:0];
    dec.jidx = instr[JIDX_W-1:0];
    unique case (opc)
      OP_SPECIAL: if (fn == FN_JREG) dec.flow = FLOW_JREG;
      OP_REGIMM: begin
        dec.flow = FLOW_BRANCH;
        if (sub == SUB_LTZ)      dec.test = TEST_LTZ;
        else if (sub == SUB_GEZ) dec.test = TEST_GEZ;
        else                     dec.test = TEST_NEVER;
      end
      OP_JUMP:  dec.flow = FLOW_JABS;
      OP_JLINK: begin
        dec.flow = FLOW_JABS;
        dec.link = 1'b1;
      end
      OP_BREQ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_EQ;
      end
      OP_BRNE: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_NE;
      end
      OP_BRLEZ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_LEZ;
      end
      OP_BRGTZ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_GTZ;
      end
      default: dec.flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  test_e           test,
  output logic            taken
);
  logic is_neg;
  logic is_zero;
  logic is_eq;

  assign is_neg  = rs_val[XLEN-1];
  assign is_zero = (rs_val == '0);
  assign is_eq   = (rs_val == rt_val);

  always_comb begin
    unique case (test)
      TEST_EQ:  taken = is_eq;
      TEST_NE:  taken = !is_eq;
      TEST_LTZ: taken = is_neg;
      TEST_GEZ: taken = !is_neg;
      TEST_LEZ: taken = is_neg || is_zero;
      TEST_GTZ: taken = !is_neg && !is_zero;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   ret_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   jabs_pc
);
  localparam int unsigned WORD_B   = 4;
  localparam int unsigned ALIGN_W  = 2;
  localparam int unsigned REGION_W = XLEN - JIDX_W - ALIGN_W;
  localparam int unsigned SEXT_W   = XLEN - OFS_W - ALIGN_W;

  logic [XLEN-1:0] ofs_bytes;

  assign seq_pc    = pc + XLEN'(WORD_B);
  assign ret_pc    = pc + XLEN'(2 * WORD_B);
  assign ofs_bytes = {{SEXT_W{ofs[OFS_W-1]}}, ofs, {ALIGN_W{1'b0}}};
  assign br_pc     = seq_pc + ofs_bytes;
  assign jabs_pc   = {seq_pc[XLEN-1 -: REGION_W], jidx, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [XLEN-1:0]   link_val
);
  dec_t            dec;
  logic            taken;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] ret_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jabs_pc;

  npc_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .rs_val (rs_val),
    .rt_val (rt_val),
    .test   (dec.test),
    .taken  (taken)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc      (pc),
    .ofs     (dec.ofs),
    .jidx    (dec.jidx),
    .seq_pc  (seq_pc),
    .ret_pc  (ret_pc),
    .br_pc   (br_pc),
    .jabs_pc (jabs_pc)
  );

  always_comb begin
    unique case (dec.flow)
      FLOW_JABS:   next_pc = jabs_pc;
      FLOW_JREG:   next_pc = rs_val;
      FLOW_BRANCH: next_pc = taken ? br_pc : seq_pc;
      default:     next_pc = seq_pc;
    endcase
  end

  assign link_we  = dec.link;
  assign link_val = ret_pc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [XLEN-1:0] pc,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] next_pc,
  input logic            link_we,
  input logic [XLEN-1:0] link_val
);
  logic [5:0]      op;
  logic [XLEN-1:0] inc;
  logic            known;

  assign op    = instr[31:26];
  assign inc   = pc + XLEN'(4);
  assign known = !$isunknown({pc, instr, rs_val, rt_val, next_pc, link_we, link_val});

  always_comb begin
    if (known) begin
      assert_plain_flow_R1: assert (!((op > 6'h07) || (op == 6'h00 && instr[5:0] != 6'h08))
                                    || (next_pc == inc && !link_we))
        else $error("R1 sequential flow broken");
      assert_link_only_call_R3: assert (!link_we || op == 6'h03)
        else $error("R3 link enable outside call");
      assert_link_value_R3: assert (link_val - pc == XLEN'(8))
        else $error("R3 link value");
      assert_jreg_R4: assert (!(op == 6'h00 && instr[5:0] == 6'h08) || next_pc == rs_val)
        else $error("R4 register jump");
      assert_branch_align_R5: assert (!(op >= 6'h04 && op <= 6'h07) || next_pc[1:0] == pc[1:0])
        else $error("R5 branch alignment");
      assert_bad_sub_R6: assert (!(op == 6'h01 && instr[20:17] != 4'd0) || next_pc == inc)
        else $error("R6 unknown sub-opcode taken");
      assert_region_R8: assert (!(op == 6'h02 || op == 6'h03)
                                || next_pc[XLEN-1:XLEN-4] == inc[XLEN-1:XLEN-4])
        else $error("R8 jump region");
    end
  end
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .pc       (pc),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .next_pc  (next_pc),
  .link_we  (link_we),
  .link_val (link_val)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, instr, rs_val, rt_val;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  always #2 clk = ~clk;

  npc_unit dut (
    .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  function automatic string tag_of(input logic [31:0] i);
    case (i[31:26])
      6'h00: return (i[5:0] == 6'h08) ? "R4" : "R1";
      6'h01: return "R6";
      6'h02: return "R2";
      6'h03: return "R3";
      6'h04, 6'h05: return "R5";
      6'h06, 6'h07: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] e_pc, output logic e_we);
    int signed   sa;
    logic [31:0] fall, jump, brt;
    bit          tk;
    sa   = a;
    fall = p + 32'd4;
    jump = (fall & 32'hF000_0000) | ({6'd0, i[25:0]} * 4);
    brt  = fall + 32'(int'($signed(i[15:0])) * 4);
    e_we = (i[31:26] == 6'h03);
    tk   = 1'b0;
    e_pc = fall;
    case (i[31:26])
      6'h00: if (i[5:0] == 6'h08) e_pc = a;
      6'h02, 6'h03: e_pc = jump;
      6'h04: tk = (a == b);
      6'h05: tk = (a != b);
      6'h01: tk = (i[20:16] == 5'd0) ? (sa < 0) : (i[20:16] == 5'd1) ? (sa >= 0) : 1'b0;
      6'h06: tk = (sa <= 0);
      6'h07: tk = (sa > 0);
      default: ;
    endcase
    if (tk) e_pc = brt;
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b, input string note);
    logic [31:0] e_pc;
    logic        e_we;
    string       t;
    @(posedge clk);
    pc = p; instr = i; rs_val = a; rt_val = b;
    model(p, i, a, b, e_pc, e_we);
    t = tag_of(i);
    @(negedge clk);
    n_chk++;
    if (next_pc !== e_pc) begin
      n_bad++;
      $display("FAIL %s %s next_pc actual=%h expected=%h", t, note, next_pc, e_pc);
    end
    n_chk++;
    if (link_we !== e_we) begin
      n_bad++;
      $display("FAIL R3 %s link_we actual=%b expected=%b", note, link_we, e_we);
    end
    n_chk++;
    if (link_val !== p + 32'd8) begin
      n_bad++;
      $display("FAIL R3 %s link_val actual=%h expected=%h", note, link_val, p + 32'd8);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rtf,
                                     input logic [15:0] lo);
    return {op, 5'd3, rtf, lo};
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [5:0]  ops [10];
    logic [31:0] edge_v [6];
    ops = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h23};
    edge_v = '{32'h0, 32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h55AA_0F0F};
    pc = 0; instr = 0; rs_val = 0; rt_val = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset/idle state: null instruction falls through (R1)
    apply(32'h0, 32'h0, 32'h0, 32'h0, "R1 idle");
    apply(32'hFFFF_FFFC, mk(6'h08, 5'd0, 16'h0010), 32'h0, 32'h0, "R1 wrap");
    apply(32'h0040_0000, 32'h0000_0009, 32'h1234, 32'h0, "R1 funct 0x09");
    apply(32'h0040_0100, {6'h02, 26'h3FF_FFFF}, 32'h0, 32'h0, "R2 max index");
    apply(32'h1000_0010, {6'h03, 26'h000_0040}, 32'h0, 32'h0, "R3 call");
    apply(32'h0040_0000, {6'h00, 5'd7, 15'd0, 6'h08}, 32'hABCD_1234, 32'h0, "R4 jr");
    apply(32'h0040_0000, mk(6'h04, 5'd1, 16'h0003), 32'h5, 32'h5, "R5 eq taken");
    apply(32'h0040_0000, mk(6'h04, 5'd1, 16'hFFFF), 32'h5, 32'h6, "R5 eq not taken");
    apply(32'h0040_0000, mk(6'h05, 5'd1, 16'hFFFF), 32'h5, 32'h6, "R5 ne back");
    apply(32'h0040_0000, mk(6'h05, 5'd1, 16'h0000), 32'h5, 32'h6, "R5 zero offset");
    apply(32'h0040_0000, mk(6'h01, 5'd0, 16'h0002), 32'h8000_0000, 32'h0, "R6 ltz min");
    apply(32'h0040_0000, mk(6'h01, 5'd1, 16'h0002), 32'h0, 32'h0, "R6 gez zero");
    apply(32'h0040_0000, mk(6'h01, 5'd2, 16'h0002), 32'hFFFF_FFFF, 32'h0, "R6 bad sub");
    apply(32'h0040_0000, mk(6'h06, 5'd9, 16'h0004), 32'h0, 32'h0, "R7 lez zero");
    apply(32'h0040_0000, mk(6'h07, 5'd0, 16'h0004), 32'h0, 32'h0, "R7 gtz zero");
    apply(32'h0040_0000, mk(6'h07, 5'd0, 16'h0004), 32'h7FFF_FFFF, 32'h0, "R7 gtz max");
    apply(32'h2FFF_FFFC, {6'h02, 26'h000_0010}, 32'h0, 32'h0, "R8 crosses region");
    apply(32'h2FFF_FFF8, {6'h03, 26'h000_0010}, 32'h0, 32'h0, "R8 stays in region");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] p, i, a, b;
      step_lfsr(); p = {lfsr[31:2], 2'b00};
      step_lfsr(); i = lfsr;
      i[31:26] = ops[lfsr[3:0] % 10];
      if (lfsr[7:6] == 2'b00) i[5:0] = 6'h08;
      if (lfsr[9]) i[20:16] = {3'd0, lfsr[11:10]};
      step_lfsr(); a = lfsr[2] ? edge_v[lfsr[6:4] % 6] : lfsr;
      step_lfsr(); b = lfsr[1] ? a : lfsr;
      apply(p, i, a, b, "random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule